// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station-management master. Software programs a control register with the MDC divider, a preamble-skip option and an MDIO hold delay. It then places a 32-bit clause 22 frame in the frame register. The block sends the optional preamble of ones, then the frame MSB first on MDIO. It derives MDC from the system clock. For a read operation it lets go of the line and collects the PHY's 16 reply bits into the low half of the frame register.

A transaction is launched by a register write that meets an interlock. A frame-register write launches when the low 8 bits of the control register (divider plus preamble-skip) are nonzero. A control-register write launches only when three things hold: the frame register holds a nonzero value, the old low 8 control bits are all zero, and the new low 8 bits are nonzero. Completion is flagged only once the last bit has left, not at the write. A clear issued right after the launch is therefore followed later by a new flag. The flag is sticky, cleared by writing one, and gated by a mask bit onto the interrupt pin.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Writing address 1 (frame) while idle, with control bits [7:0] nonzero, starts a transaction: event register bit 1 (busy) reads 1 right after the write and MDIO is driven.
- R2: Writing address 1 while control bits [7:0] are zero stores the value and starts nothing (busy stays 0).
- R3: Writing address 0 (control) starts a transaction only if all three hold: the frame register is nonzero, the old bits [7:0] are zero, and the new bits [7:0] are nonzero. In every other case the write only updates the register.
- R4: A transaction sends 32 ones and then the 32 frame bits MSB first, one bit per MDC period. With control bit 7 set, the ones are left out.
- R5: MDC rests low while idle. While busy, each half period lasts (control bits [6:1] + 1) system clock cycles.
- R6: MDIO changes exactly (control bits [10:8]) system clock cycles after an MDC falling edge.
- R7: When frame bits [29:28] = 2'b10 (read), MDIO output enable is low from frame bit 16 through bit 0. The 16 bits sampled on those MDC rising edges are stored MSB first in frame register bits [15:0]. For other op codes, MDIO is driven for every bit.
- R8: Event register bit 0 (done flag) is set only after the last bit completes, and not by the launching write. It is set even if it was cleared after the launch.
- R9: Writing address 2 with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged.
- R10: A frame-register write while busy is ignored: the register keeps its value and no second transaction follows.
- R11: irq equals the done flag ANDed with address 3 bit 0 (mask).
- R12: Read map: address 0 holds control bits [10:0], address 1 the frame, address 2 {busy, flag} in bits [1:0], and address 3 the mask in bit 0. After reset all registers read 0 and mdc, mdio_oe and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
Four frames are run, each with its own combination: write versus read op, preamble present or skipped, divider 1 to 3, hold delay 0 to 2, and launch by frame write versus launch by control write. A failure therefore points to the bit engine, the clock divider, the hold delay or the launch interlock. Each launch is preceded by writes that must not launch, which checks both sides of the interlock. Alternating frame bits make every hold delay visible as a line change. Distinct reply patterns expose bit order in the read capture. Directed cases clear the flag right after launch and write a second frame mid-transaction, separating the late completion event from a spurious restart.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 16;
   localparam int REG_W   = 32;

   typedef enum logic [1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_FRAME = 2'd1,
      ADDR_EVENT = 2'd2,
      ADDR_MASK  = 2'd3
   } reg_addr_e;

   localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             mdc_o,
   output logic             rise_o,
   output logic             fall_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             en;
   logic             wrap;

   assign en   = run_i && (div_i != '0);
   assign wrap = en && (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign mdc_o  = mdc_q;
   assign rise_o = wrap && !mdc_q;
   assign fall_o = wrap && mdc_q;

   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !mdc_q) else $error("mdc not low while idle"); // R5
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 6,
   parameter int HOLD_W  = 3,
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               pre_off_i,
   input  logic [HOLD_W-1:0]  hold_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic               mdc_i,
   input  logic               rise_i,
   input  logic               fall_i,
   input  logic               mdio_i,
   output logic               busy_o,
   output logic               mdio_o,
   output logic               mdio_oe_o,
   output logic               done_o,
   output logic               rd_done_o,
   output logic [DATA_W-1:0]  rd_data_o
);
   localparam int IDX_W     = $clog2(FRAME_W);
   localparam int PRE_CW    = (PRE_LEN > 0) ? $clog2(PRE_LEN + 1) : 1;
   localparam int FIRST_DAT = FRAME_W - DATA_W;
   localparam int RELEASE   = FIRST_DAT - 1;

   logic                busy_q;
   logic [FRAME_W-1:0]  fsh_q;
   logic [IDX_W-1:0]    fidx_q;
   logic                rd_q;
   logic                last_q;
   logic                hpend_q;
   logic [HOLD_W-1:0]   hcnt_q;
   logic [DATA_W-1:0]   rsh_q;
   logic                in_pre;
   logic                adv;

   assign adv = busy_q && ((fall_i && (hold_i == '0)) ||
                           (hpend_q && (hcnt_q == HOLD_W'(1))));

   if (PRE_LEN > 0) begin : g_pre
      logic [PRE_CW-1:0] pcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pcnt_q <= '0;
         else if (start_i) pcnt_q <= pre_off_i ? '0 : PRE_CW'(PRE_LEN);
         else if (adv && (pcnt_q != '0)) pcnt_q <= pcnt_q - 1'b1;
      end
      assign in_pre = (pcnt_q != '0);
   end else begin : g_nopre
      assign in_pre = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         fsh_q   <= '0;
         fidx_q  <= '0;
         rd_q    <= 1'b0;
         last_q  <= 1'b0;
         hpend_q <= 1'b0;
         hcnt_q  <= '0;
         rsh_q   <= '0;
      end else if (start_i) begin
         busy_q  <= 1'b1;
         fsh_q   <= frame_i;
         fidx_q  <= '0;
         rd_q    <= (frame_i[FRAME_W-3:FRAME_W-4] == OP_READ);
         last_q  <= 1'b0;
         hpend_q <= 1'b0;
      end else if (busy_q) begin
         if (rise_i && !in_pre) begin
            if (fidx_q == IDX_W'(FRAME_W - 1)) last_q <= 1'b1;
            if (rd_q && (fidx_q >= IDX_W'(FIRST_DAT)))
               rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
         end
         if (fall_i && (hold_i != '0)) begin
            hpend_q <= 1'b1;
            hcnt_q  <= hold_i;
         end else if (hpend_q) begin
            if (hcnt_q == HOLD_W'(1)) hpend_q <= 1'b0;
            else                      hcnt_q  <= hcnt_q - 1'b1;
         end
         if (adv) begin
            if (last_q) begin
               busy_q <= 1'b0;
            end else if (!in_pre) begin
               fsh_q  <= fsh_q << 1;
               fidx_q <= fidx_q + 1'b1;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = adv && last_q;
   assign rd_done_o = adv && last_q && rd_q;
   assign rd_data_o = rsh_q;
   assign mdio_o    = busy_q ? (in_pre ? 1'b1 : fsh_q[FRAME_W-1]) : 1'b1;
   assign mdio_oe_o = busy_q && !(rd_q && !in_pre && (fidx_q >= IDX_W'(RELEASE)));

   AST_MDIO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mdc_i && $past(mdc_i) && (32'(hold_i) <= 32'(div_i)))
      |-> $stable(mdio_o)) else $error("mdio moved while mdc high"); // R6
   AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !rd_q) |-> mdio_oe_o) else $error("write frame released"); // R7
endmodule

// File: rtl/mdio_event.sv
`timescale 1ns/1ps
module mdio_event (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_wr_i,
   input  logic mask_d_i,
   output logic flag_o,
   output logic mask_o,
   output logic irq_o
);
   logic flag_q;
   logic mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= 1'b0;
      else if (mask_wr_i) mask_q <= mask_d_i;
   end

   assign flag_o = flag_q;
   assign mask_o = mask_q;
   assign irq_o  = flag_q & mask_q;

   AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q) else $error("done did not set flag"); // R8
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q) else $error("clear ignored"); // R9
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 6,
   parameter int HOLD_W  = 3,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_i,
   input  logic [1:0]  reg_addr_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   output logic        mdc_o,
   output logic        mdio_o,
   output logic        mdio_oe_o,
   input  logic        mdio_i,
   output logic        irq_o
);
   localparam int PRE_BIT  = DIV_W + 1;
   localparam int SPD_W    = DIV_W + 2;
   localparam int HOLD_LSB = DIV_W + 2;
   localparam int CTRL_W   = HOLD_LSB + HOLD_W;

   initial begin
      assert (DIV_W >= 1) else $error("DIV_W must be at least 1");
      assert (HOLD_W >= 1) else $error("HOLD_W must be at least 1");
      assert (CTRL_W <= REG_W) else $error("control fields exceed register");
      assert (PRE_LEN < 64) else $error("PRE_LEN too large");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [FRAME_W-1:0] frame_q;
   logic               busy, done, rd_done, flag, mask;
   logic [DATA_W-1:0]  rd_data;
   logic               rise, fall, mdc;
   logic               wr_ctrl, wr_frame, wr_event, wr_mask;
   logic               start_frame, start_ctrl, start;
   logic [SPD_W-1:0]   speed_cur, speed_new;

   assign wr_ctrl  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
   assign wr_frame = reg_wr_i && (reg_addr_i == ADDR_FRAME);
   assign wr_event = reg_wr_i && (reg_addr_i == ADDR_EVENT);
   assign wr_mask  = reg_wr_i && (reg_addr_i == ADDR_MASK);

   assign speed_cur = ctrl_q[SPD_W-1:0];
   assign speed_new = reg_wdata_i[SPD_W-1:0];

   assign start_frame = wr_frame && !busy && (speed_cur != '0);
   assign start_ctrl  = wr_ctrl && !busy && (frame_q != '0) &&
                        (speed_cur == '0) && (speed_new != '0);
   assign start       = start_frame || start_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  frame_q <= '0;
      else if (wr_frame && !busy)  frame_q <= reg_wdata_i;
      else if (rd_done)            frame_q[DATA_W-1:0] <= rd_data;
   end

   mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy),
      .div_i  (ctrl_q[DIV_W:1]),
      .mdc_o  (mdc),
      .rise_o (rise),
      .fall_o (fall)
   );

   mdio_shifter #(.DIV_W(DIV_W), .HOLD_W(HOLD_W), .PRE_LEN(PRE_LEN)) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .frame_i   (start_frame ? reg_wdata_i : frame_q),
      .pre_off_i (start_ctrl ? reg_wdata_i[PRE_BIT] : ctrl_q[PRE_BIT]),
      .hold_i    (ctrl_q[HOLD_LSB +: HOLD_W]),
      .div_i     (ctrl_q[DIV_W:1]),
      .mdc_i     (mdc),
      .rise_i    (rise),
      .fall_i    (fall),
      .mdio_i    (mdio_i),
      .busy_o    (busy),
      .mdio_o    (mdio_o),
      .mdio_oe_o (mdio_oe_o),
      .done_o    (done),
      .rd_done_o (rd_done),
      .rd_data_o (rd_data)
   );

   mdio_event event_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (done),
      .clr_i     (wr_event && reg_wdata_i[0]),
      .mask_wr_i (wr_mask),
      .mask_d_i  (reg_wdata_i[0]),
      .flag_o    (flag),
      .mask_o    (mask),
      .irq_o     (irq_o)
   );

   assign mdc_o = mdc;

   always_comb begin
      unique case (reg_addr_i)
         ADDR_CTRL:  reg_rdata_o = {{(REG_W - CTRL_W){1'b0}}, ctrl_q};
         ADDR_FRAME: reg_rdata_o = frame_q;
         ADDR_EVENT: reg_rdata_o = {{(REG_W - 2){1'b0}}, busy, flag};
         default:    reg_rdata_o = {{(REG_W - 1){1'b0}}, mask};
      endcase
   end

   AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr_i && !reg_addr_i[1]))
      else $error("transaction began without a launching write"); // R1
   AST_FRAME_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_frame && busy && !rd_done) |=> $stable(frame_q))
      else $error("frame changed while busy"); // R10
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
   typedef struct packed {
      logic [31:0] ctrl;
      logic [31:0] frame;
      logic [15:0] phy;
      logic        via_ctrl;
      logic [31:0] exp_rb;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{32'h0000_0104, 32'h528E_A5C3, 16'h0000, 1'b0, 32'h528E_A5C3},
      '{32'h0000_0082, 32'h6088_0000, 16'h3C5A, 1'b1, 32'h6088_3C5A},
      '{32'h0000_0206, 32'h5AA6_5A5A, 16'h0000, 1'b1, 32'h5AA6_5A5A},
      '{32'h0000_0104, 32'h6BFE_0000, 16'hF00F, 1'b0, 32'h6BFE_F00F}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_in, irq;
   logic        phy_bit;

   int n_chk = 0;
   int n_fail = 0;
   int nrise = 0, base = 0, cur_pre = 0, cur_hold = 0;
   logic [15:0] cur_phy = '0;
   logic [63:0] cap_o = '0, cap_oe = '0;
   int cyc = 0, vstart = 0, fall_cyc = -1, rise_cyc = -1;
   int hi_len = 0, lo_len = 0, hold_n = 0, hold_bad = 0;
   logic prev_mdc = 1'b0, prev_o = 1'b1;
   int k;

   always #2.5 clk = ~clk;

   mdio_mgmt_master dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .mdc_o       (mdc),
      .mdio_o      (mdio_o),
      .mdio_oe_o   (mdio_oe),
      .mdio_i      (mdio_in),
      .irq_o       (irq)
   );

   // Simple PHY: reply bits follow the count of MDC rises in the frame
   always @* begin
      k = nrise - base - cur_pre - 16;
      phy_bit = (k >= 0 && k < 16) ? cur_phy[15 - k] : 1'b1;
   end
   assign mdio_in = mdio_oe ? mdio_o : phy_bit;

   always @(posedge mdc) begin
      cap_o  = {cap_o[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe};
      nrise  = nrise + 1;
   end

   always @(negedge clk) begin
      if (prev_mdc && !mdc) begin
         if (rise_cyc >= vstart) hi_len = cyc - rise_cyc;
         fall_cyc = cyc;
      end
      if (!prev_mdc && mdc) begin
         if (fall_cyc >= vstart) lo_len = cyc - fall_cyc;
         rise_cyc = cyc;
      end
      if (mdio_o != prev_o && !mdc && fall_cyc >= vstart) begin
         hold_n = hold_n + 1;
         if (cyc - fall_cyc != cur_hold) hold_bad = hold_bad + 1;
      end
      prev_mdc = mdc;
      prev_o   = mdio_o;
      cyc      = cyc + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] r;
      int n = 0;
      rd(2'd2, r);
      while (r[1] && n < 5000) begin
         @(negedge clk);
         rd(2'd2, r);
         n++;
      end
      chk(!r[1], "R8 completion reached", 64'(r[1]), 64'h0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [63:0] full, expv, oe_exp;
      int hb0, hn0, nbits, dv, hd;
      bit pre, rdop;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), r);
         chk(r == 32'h0, "R12 reset register", 64'(r), 64'h0);
      end
      chk(!mdc && !mdio_oe && !irq, "R12 reset pins",
          64'({mdc, mdio_oe, irq}), 64'h0);

      for (int i = 0; i < 4; i++) begin
         dv   = int'(VECS[i].ctrl[6:1]);
         hd   = int'(VECS[i].ctrl[10:8]);
         pre  = !VECS[i].ctrl[7];
         rdop = (VECS[i].frame[29:28] == 2'b10);
         cur_pre  = pre ? 32 : 0;
         cur_hold = hd;
         cur_phy  = VECS[i].phy;
         wr(2'd0, 32'h0);
         wr(2'd2, 32'h1);
         vstart = cyc; base = nrise; hb0 = hold_bad; hn0 = hold_n;
         if (VECS[i].via_ctrl) begin
            wr(2'd1, VECS[i].frame);
            rd(2'd2, r);
            chk(r[1] == 1'b0, "R2 frame write with zero speed", 64'(r), 64'h0);
            wr(2'd0, VECS[i].ctrl);
            rd(2'd2, r);
            chk(r[1] == 1'b1, "R3 control write launch", 64'(r[1]), 64'h1);
         end else begin
            wr(2'd1, 32'h0);
            wr(2'd0, VECS[i].ctrl);
            rd(2'd2, r);
            chk(r[1] == 1'b0, "R3 no launch with empty frame", 64'(r), 64'h0);
            wr(2'd1, VECS[i].frame);
            rd(2'd2, r);
            chk(r[1] == 1'b1, "R1 frame write launch", 64'(r[1]), 64'h1);
         end
         chk(r[0] == 1'b0, "R8 flag clear at launch", 64'(r[0]), 64'h0);
         wait_idle();
         rd(2'd2, r);
         chk(r[0] == 1'b1, "R8 flag after completion", 64'(r[0]), 64'h1);
         nbits = pre ? 64 : 32;
         chk(nrise - base == nbits, "R4 bit count", 64'(nrise - base), 64'(nbits));
         full   = pre ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
         expv   = pre ? {32'hFFFF_FFFF, VECS[i].frame} : {32'h0, VECS[i].frame};
         oe_exp = rdop ? (full & ~64'h1_FFFF) : full;
         chk((cap_o & oe_exp) == (expv & oe_exp), "R4 serial stream",
             cap_o & oe_exp, expv & oe_exp);
         chk((cap_oe & full) == oe_exp, "R7 output enable pattern",
             cap_oe & full, oe_exp);
         rd(2'd1, r);
         chk(r == VECS[i].exp_rb, "R7 frame readback", 64'(r), 64'(VECS[i].exp_rb));
         chk(hi_len == dv + 1 && lo_len == dv + 1, "R5 half period",
             64'({hi_len[15:0], lo_len[15:0]}), 64'({16'(dv + 1), 16'(dv + 1)}));
         chk(hold_bad == hb0 && hold_n > hn0, "R6 hold delay",
             64'(hold_bad - hb0), 64'h0);
      end

      // R9 / R11: sticky flag and mask
      wr(2'd2, 32'h0);
      rd(2'd2, r);
      chk(r[0] == 1'b1, "R9 write zero keeps flag", 64'(r[0]), 64'h1);
      chk(irq == 1'b0, "R11 masked irq low", 64'(irq), 64'h0);
      wr(2'd3, 32'h1);
      rd(2'd3, r);
      chk(r == 32'h1, "R12 mask readback", 64'(r), 64'h1);
      #1 chk(irq == 1'b1, "R11 irq with mask", 64'(irq), 64'h1);
      wr(2'd2, 32'h1);
      rd(2'd2, r);
      chk(r[0] == 1'b0 && irq == 1'b0, "R9 write one clears",
          64'({r[0], irq}), 64'h0);

      // R3: control write with speed already nonzero does not launch
      wr(2'd0, 32'h0000_0106);
      rd(2'd2, r);
      chk(r[1] == 1'b0, "R3 no launch from nonzero speed", 64'(r), 64'h0);
      rd(2'd0, r);
      chk(r == 32'h106, "R12 control readback", 64'(r), 64'h106);

      // R8 late event after clear, R10 write while busy ignored
      cur_pre = 32; cur_hold = 1; vstart = cyc; base = nrise;
      wr(2'd1, 32'h5123_4567);
      wr(2'd2, 32'h1);
      rd(2'd2, r);
      chk(r[1:0] == 2'b10, "R8 cleared while busy", 64'(r[1:0]), 64'h2);
      wr(2'd1, 32'h5FFF_FFFF);
      rd(2'd1, r);
      chk(r == 32'h5123_4567, "R10 frame held while busy", 64'(r), 64'h5123_4567);
      wait_idle();
      chk(nrise - base == 64 && cap_o[31:0] == 32'h5123_4567,
          "R10 single transaction", 64'(cap_o[31:0]), 64'h5123_4567);
      rd(2'd2, r);
      chk(r[0] == 1'b1 && irq == 1'b1, "R8 late completion event",
          64'({r[0], irq}), 64'h3);

      summary();
      $finish;
   end
endmodule